// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

The router collects up to 64 level-sensitive device interrupt lines into one raw request vector and presents it to four processors. Each processor owns a 64-bit enable mask. A processor's interrupt output is high while at least one bit is both pending and enabled for that processor. One fixed bit of the raw vector is driven by the output of a cascaded legacy interrupt controller, not by the general line input.

Software reaches the block through a 32-bit CSR port. Every register is 64 bits wide and is moved in two 32-bit halves through a shared half-word latch. On a write, the low half is held in the latch and the whole value is committed when the high half arrives. On a read, the low half is returned and the high half is held in the latch, so that the next access can return it. Each processor has a mask register and a read-only view of its masked request. The raw vector is also read-only.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high and after it falls, all four masks, the raw vector, `cpu_irq`, `csr_rdata`, `csr_rvalid` and `csr_err` are zero.
- R2: Raw bit n (n other than 55) equals `irq_lines[n]` as sampled at the previous rising edge. It follows the level in both directions and holds no memory of earlier pulses.
- R3: Raw bit 55 follows `legacy_irq` with the same one-edge delay, and `irq_lines[55]` has no effect on the raw vector.
- R4: `cpu_irq[i]` is high exactly when CPU i's mask AND the raw vector was nonzero at the previous edge. A line change therefore shows on the output two edges later, and a mask commit shows one edge later.
- R5: The mask registers for CPU0..CPU3 are at byte offsets 0x200, 0x240, 0x600 and 0x640. The masked-request registers, which read as mask AND raw, are at 0x280, 0x2C0, 0x680 and 0x6C0. The raw vector is at 0x300.
- R6: A write with `csr_hi`=0 only loads the latch. A write with `csr_hi`=1 commits {`csr_wdata`, latch} to the addressed mask. A low-half write on its own leaves every mask unchanged.
- R7: A read with `csr_hi`=0 returns bits 31:0 on `csr_rdata`, with `csr_rvalid` high, one edge after the request, and loads bits 63:32 into the latch. A read with `csr_hi`=1 returns the latch contents.
- R8: Writes to the masked-request offsets and to the raw offset change no mask and no raw bit.
- R9: A mask write changes only the addressed CPU's mask.
- R10: An access to any other offset returns `csr_rdata`=0 and raises `csr_err` for one cycle, one edge after the request. It changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 64 | Device interrupt levels, one per raw bit (bit 55 unused) |
| legacy_irq | input | 1 | Cascaded legacy controller output, drives raw bit 55 |
| csr_req | input | 1 | CSR access strobe, one access per cycle |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_hi | input | 1 | 1 = upper 32-bit half, 0 = lower half |
| csr_addr | input | 12 | Byte offset of the register |
| csr_wdata | input | 32 | Write data half-word |
| csr_rdata | output | 32 | Read data half-word, registered |
| csr_rvalid | output | 1 | Read data valid, one cycle after a read request |
| csr_err | output | 1 | One-cycle pulse for an unmapped offset |
| cpu_irq | output | 4 | Per-CPU interrupt request |

## Verification
The routing is tried with masks that are disjoint per CPU, with single bits placed at the low word, the high word and the legacy bit. A wrong CPU output, or a swapped half, then shows up as a different output bit rather than a coincidental match. The raw vector is driven with asymmetric patterns that are set, partly cleared and set again, which separates level-following from latching, and separates the legacy source from line 55. Edge-exact sampling after line changes and after mask commits tells the intended register depth apart from a design that is one stage faster or slower. Writes to read-only and unmapped offsets, and lone low-half writes, are followed by read-back of all four masks to expose aliasing or an early commit.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_MASK = 2'd1,
    RK_MREQ = 2'd2,
    RK_RAW  = 2'd3
  } reg_kind_e;

  localparam int unsigned RAW_OFFSET  = 'h300;
  localparam int unsigned MREQ_STRIDE = 'h80;

  // CPU pairs share a 0x400-spaced bank; the odd CPU sits 0x40 above.
  function automatic int unsigned mask_offset(input int unsigned cpu);
    return 'h200 + (cpu / 2) * 'h400 + (cpu % 2) * 'h40;
  endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_CPU-1:0]                  mask_we,
  input  logic [NUM_LINES-1:0]                wr_data,
  input  logic [NUM_LINES-1:0]                raw_q,
  output logic [NUM_CPU-1:0][NUM_LINES-1:0]   mask_q,
  output logic [NUM_CPU-1:0]                  irq_q
);

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[g] <= '0;
        irq_q[g]  <= 1'b0;
      end else begin
        if (mask_we[g]) mask_q[g] <= wr_data;
        irq_q[g] <= |(mask_q[g] & raw_q);
      end
    end

    // R9: a mask only moves when its own strobe fired
    a_r9_mask_isolated: assert property (@(posedge clk) disable iff (rst)
      !mask_we[g] |=> $stable(mask_q[g]));

    // R4: output reflects previous-cycle mask and raw state
    a_r4_irq_level: assert property (@(posedge clk) disable iff (rst)
      irq_q[g] == (|($past(mask_q[g]) & $past(raw_q))));
  end

endmodule

// File: rtl/irq_csr_if.sv
module irq_csr_if
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req,
  input  logic                               we,
  input  logic                               hi,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [NUM_LINES/2-1:0]             wdata,
  input  logic [NUM_CPU-1:0][NUM_LINES-1:0]  mask_q,
  input  logic [NUM_CPU-1:0][NUM_LINES-1:0]  mreq,
  input  logic [NUM_LINES-1:0]               raw_q,
  output logic [NUM_CPU-1:0]                 mask_we,
  output logic [NUM_LINES-1:0]               wr_data,
  output logic [NUM_LINES/2-1:0]             rdata,
  output logic                               rvalid,
  output logic                               err
);

  localparam int HALF_W = NUM_LINES / 2;
  localparam int CIDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  reg_kind_e         kind;
  logic [CIDX_W-1:0] idx;
  logic [NUM_LINES-1:0] sel_val;
  logic [HALF_W-1:0] half_latch;

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (addr == ADDR_W'(mask_offset(i))) begin
        kind = RK_MASK;
        idx  = CIDX_W'(i);
      end
      if (addr == ADDR_W'(mask_offset(i) + MREQ_STRIDE)) begin
        kind = RK_MREQ;
        idx  = CIDX_W'(i);
      end
    end
    if (addr == ADDR_W'(RAW_OFFSET)) kind = RK_RAW;
  end

  always_comb begin
    case (kind)
      RK_MASK: sel_val = mask_q[idx];
      RK_MREQ: sel_val = mreq[idx];
      RK_RAW:  sel_val = raw_q;
      default: sel_val = '0;
    endcase
  end

  assign wr_data = {wdata, half_latch};

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_we
    assign mask_we[g] = req & we & hi & (kind == RK_MASK) & (idx == CIDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_latch <= '0;
      rdata      <= '0;
      rvalid     <= 1'b0;
      err        <= 1'b0;
    end else begin
      rvalid <= req & ~we;
      err    <= req & (kind == RK_NONE);
      if (req && kind != RK_NONE && !hi)
        half_latch <= we ? wdata : sel_val[NUM_LINES-1:HALF_W];
      if (req && !we)
        rdata <= (kind == RK_NONE) ? '0 : (hi ? half_latch : sel_val[HALF_W-1:0]);
      else
        rdata <= '0;
    end
  end

  // R10: an error cycle never carries data
  a_r10_err_zero: assert property (@(posedge clk) disable iff (rst)
    err |-> (rdata == '0));

  // R10: error only follows a request
  a_r10_err_after_req: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req));

  // R7: read data valid only after a read request
  a_r7_rvalid_src: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(req && !we));

  // R9: at most one mask written per access
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_we));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int NUM_LINES  = 64,
  parameter int ADDR_W     = 12,
  parameter int LEGACY_BIT = 55
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_LINES-1:0]   irq_lines,
  input  logic                   legacy_irq,
  input  logic                   csr_req,
  input  logic                   csr_we,
  input  logic                   csr_hi,
  input  logic [ADDR_W-1:0]      csr_addr,
  input  logic [NUM_LINES/2-1:0] csr_wdata,
  output logic [NUM_LINES/2-1:0] csr_rdata,
  output logic                   csr_rvalid,
  output logic                   csr_err,
  output logic [NUM_CPU-1:0]     cpu_irq
);

  logic [NUM_LINES-1:0]              raw_d, raw_q;
  logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q, mreq;
  logic [NUM_CPU-1:0]                mask_we;
  logic [NUM_LINES-1:0]              wr_data;

  always_comb begin
    raw_d             = irq_lines;
    raw_d[LEGACY_BIT] = legacy_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_d;
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_mreq
    assign mreq[g] = mask_q[g] & raw_q;
  end

  irq_mask_bank #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES)) u_bank (
    .clk(clk), .rst(rst), .mask_we(mask_we), .wr_data(wr_data),
    .raw_q(raw_q), .mask_q(mask_q), .irq_q(cpu_irq)
  );

  irq_csr_if #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst(rst), .req(csr_req), .we(csr_we), .hi(csr_hi),
    .addr(csr_addr), .wdata(csr_wdata), .mask_q(mask_q), .mreq(mreq),
    .raw_q(raw_q), .mask_we(mask_we), .wr_data(wr_data),
    .rdata(csr_rdata), .rvalid(csr_rvalid), .err(csr_err)
  );

  // R3: legacy source owns its raw bit
  a_r3_legacy_bit: assert property (@(posedge clk) disable iff (rst)
    raw_q[LEGACY_BIT] == $past(legacy_irq));

  // R2: other raw bits follow their lines
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_rawchk
    if (g != LEGACY_BIT) begin : g_line
      a_r2_raw_follows: assert property (@(posedge clk) disable iff (rst)
        raw_q[g] == $past(irq_lines[g]));
    end
  end

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] irq_lines;
  logic        legacy_irq;
  logic        csr_req, csr_we, csr_hi;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        csr_rvalid, csr_err;
  logic [3:0]  cpu_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .legacy_irq(legacy_irq),
    .csr_req(csr_req), .csr_we(csr_we), .csr_hi(csr_hi), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid),
    .csr_err(csr_err), .cpu_irq(cpu_irq)
  );

  localparam logic [11:0] MASK_A [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
  localparam logic [11:0] MREQ_A [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};
  localparam logic [11:0] RAW_A      = 12'h300;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr64(input logic [11:0] a, input logic [63:0] v);
    @(negedge clk);
    csr_req = 1; csr_we = 1; csr_hi = 0; csr_addr = a; csr_wdata = v[31:0];
    @(negedge clk);
    csr_hi = 1; csr_wdata = v[63:32];
    @(negedge clk);
    csr_req = 0; csr_we = 0; csr_hi = 0;
  endtask

  task automatic rd64(input logic [11:0] a, output logic [63:0] v, output bit e, output bit rv);
    @(negedge clk);
    csr_req = 1; csr_we = 0; csr_hi = 0; csr_addr = a;
    @(negedge clk);
    v[31:0] = csr_rdata; e = csr_err; rv = csr_rvalid;
    csr_hi = 1;
    @(negedge clk);
    v[63:32] = csr_rdata; e = e | csr_err; rv = rv & csr_rvalid;
    csr_req = 0; csr_hi = 0;
  endtask

  logic [63:0] exp_mask [4];

  task automatic check_masks(input string tag);
    logic [63:0] v; bit e, rv;
    for (int i = 0; i < 4; i++) begin
      rd64(MASK_A[i], v, e, rv);
      chk(v == exp_mask[i] && !e && rv, tag, v, exp_mask[i]);
    end
  endtask

  task automatic t_reset();
    logic [63:0] v; bit e, rv;
    chk(cpu_irq == 0 && csr_rdata == 0 && !csr_err && !csr_rvalid, "R1 outputs after reset",
        {cpu_irq, csr_rdata, csr_err, csr_rvalid}, 64'h0);
    rd64(RAW_A, v, e, rv);
    chk(v == 64'h0, "R1 raw after reset", v, 64'h0);
    check_masks("R1 masks after reset");
  endtask

  task automatic t_raw_follow();
    logic [63:0] v; bit e, rv;
    @(negedge clk); irq_lines = 64'hA5A5_0000_0000_C301;
    rd64(RAW_A, v, e, rv);
    chk(v == 64'hA525_0000_0000_C301 && rv, "R2 raw pattern A (R3 bit 55 from legacy)", v, 64'hA525_0000_0000_C301);
    @(negedge clk); irq_lines = 64'h0005_0000_0000_0300;
    rd64(RAW_A, v, e, rv);
    chk(v == 64'h0005_0000_0000_0300, "R2 raw bits clear with lines", v, 64'h0005_0000_0000_0300);
    @(negedge clk); irq_lines = 64'h0080_0000_0000_0000; legacy_irq = 0;
    rd64(RAW_A, v, e, rv);
    chk(v == 64'h0, "R3 line 55 ignored", v, 64'h0);
    @(negedge clk); irq_lines = 64'h0; legacy_irq = 1;
    rd64(RAW_A, v, e, rv);
    chk(v == 64'h0080_0000_0000_0000, "R3 legacy drives bit 55", v, 64'h0080_0000_0000_0000);
    @(negedge clk); legacy_irq = 0;
  endtask

  task automatic t_routing();
    logic [63:0] v; bit e, rv;
    exp_mask[0] = 64'h0000_0000_0000_0008;
    exp_mask[1] = 64'h0000_0100_0000_0000;
    exp_mask[2] = 64'h0080_0000_0000_0000;
    exp_mask[3] = 64'h0000_0000_0000_0000;
    for (int i = 0; i < 4; i++) wr64(MASK_A[i], exp_mask[i]);
    check_masks("R5 R9 mask read-back");
    @(negedge clk); irq_lines = 64'h8;
    @(negedge clk);
    chk(cpu_irq == 4'b0000, "R4 output not yet after one edge", cpu_irq, 4'b0000);
    @(negedge clk);
    chk(cpu_irq == 4'b0001, "R4 cpu0 after two edges", cpu_irq, 4'b0001);
    irq_lines = 64'h0000_0100_0000_0008; legacy_irq = 1;
    @(negedge clk); @(negedge clk);
    chk(cpu_irq == 4'b0111, "R4 cpu0 cpu1 cpu2 routed", cpu_irq, 4'b0111);
    for (int i = 0; i < 4; i++) begin
      rd64(MREQ_A[i], v, e, rv);
      chk(v == exp_mask[i] && !e, "R5 masked-request view", v, exp_mask[i]);
    end
    wr64(MASK_A[0], 64'h0);
    exp_mask[0] = 64'h0;
    chk(cpu_irq == 4'b0111, "R4 output holds one edge after commit", cpu_irq, 4'b0111);
    @(negedge clk);
    chk(cpu_irq == 4'b0110, "R4 cpu0 drops after mask clear", cpu_irq, 4'b0110);
  endtask

  task automatic t_half_write();
    logic [63:0] v; bit e, rv;
    @(negedge clk);
    csr_req = 1; csr_we = 1; csr_hi = 0; csr_addr = MASK_A[1]; csr_wdata = 32'hDEAD_BEEF;
    @(negedge clk); csr_req = 0; csr_we = 0;
    check_masks("R6 lone low-half write has no effect");
    wr64(MASK_A[3], 64'h1234_5678_9ABC_DEF0);
    exp_mask[3] = 64'h1234_5678_9ABC_DEF0;
    rd64(MASK_A[3], v, e, rv);
    chk(v == exp_mask[3] && rv, "R7 R6 both halves in order", v, exp_mask[3]);
  endtask

  task automatic t_ro_writes();
    logic [63:0] v; bit e, rv;
    wr64(MREQ_A[2], 64'hFFFF_FFFF_FFFF_FFFF);
    wr64(RAW_A, 64'hFFFF_FFFF_FFFF_FFFF);
    check_masks("R8 read-only writes leave masks");
    rd64(RAW_A, v, e, rv);
    chk(v == 64'h0080_0100_0000_0008, "R8 raw unchanged by write", v, 64'h0080_0100_0000_0008);
  endtask

  task automatic t_unmapped();
    @(negedge clk);
    csr_req = 1; csr_we = 0; csr_hi = 0; csr_addr = 12'h100;
    @(negedge clk); csr_req = 0;
    chk(csr_err == 1 && csr_rdata == 0, "R10 unmapped read error and zero",
        {csr_err, csr_rdata}, {1'b1, 32'h0});
    @(negedge clk);
    chk(csr_err == 0, "R10 error is one cycle", csr_err, 0);
    wr64(12'h208, 64'hFFFF_FFFF_FFFF_FFFF);
    check_masks("R10 unmapped write changes nothing");
  endtask

  initial begin
    rst = 1; irq_lines = 0; legacy_irq = 0;
    csr_req = 0; csr_we = 0; csr_hi = 0; csr_addr = 0; csr_wdata = 0;
    for (int i = 0; i < 4; i++) exp_mask[i] = 64'h0;
    repeat (3) @(negedge clk);
    chk(cpu_irq == 0 && !csr_err, "R1 during reset", {cpu_irq, csr_err}, 64'h0);
    rst = 0;
    t_reset();
    t_raw_follow();
    t_routing();
    t_half_write();
    t_ro_writes();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule